// File: doc/BRIEF.md
# Programmable Static Memory Bus Controller

This block connects an internal request port to an asynchronous parallel bus that serves up to six external devices, such as NOR flash or memory-mapped peripherals. Each request carries a direction, a 32-bit system address and 16-bit write data. The controller matches the address against six fixed windows and picks the chip select whose window contains it. It then forms a 9-bit halfword address from the offset inside that window. The access runs through a sequence of phases: turnaround recovery, first-access latency, strobe and write hold. The length of each phase comes from the timing word of the chip select that was hit.

Software gives every chip select its own timing word through a small write-only register port. One 32-bit word holds all the fields of one chip select. The block accepts one request at a time. Each request ends with a response pulse that carries read data or an error flag. Addresses outside all six windows never reach the bus.

Top module: `xbus_ctrl`

## Requirements
- R1: Address windows. The windows map to chip selects as follows. 0x1A800000..0x1AFFFFFF selects chip select 0. 0x1B000000..0x1B7FFFFF selects 1. 0x1B800000..0x1BFFFFFF selects 2. 0x1D000000..0x24FFFFFF selects 3. 0x1C800000..0x1CFFFFFF selects 4. 0x1C000000..0x1C7FFFFF selects 5. During an access, only bit i of `bus_cs_n` is low, where i is the selected chip select. `bus_addr` is bits [9:1] of (address minus window base).
- R2: Unmapped addresses. An address outside every window drives no chip select and no strobe. The response comes in the cycle after acceptance, with `rsp_err`=1 and `rsp_rdata`=0.
- R3: Strobe width. The strobe stays active for read-wait+1 cycles: OE for a read, WE for a write (write-wait+1 cycles). `bus_adv_n` is low in the first strobe cycle only.
- R4: Write hold. After WE rises, the chip select stays low and the write data stays driven for write-hold+1 cycles. A write response returns `rsp_rdata`=0.
- R5: First-access latency. An access gets extra read-delta or write-delta cycles before its strobe, with the chip select low and no strobe. This happens when its chip select, or its `bus_addr[8:4]`, differs from the previous access in the same direction, or when it is the first access in that direction after reset. Other accesses get no extra cycles.
- R6: Recovery. After a read, the next access gets recovery cycles with every chip select high if it goes to a different chip select or is a write. The count is the recovery field of the chip select that was read, with a minimum of 1. It applies however long the bus has been idle. After a write, or for a read that follows a read on the same chip select, no recovery is added.
- R7: Read return. Read data is sampled from `bus_dq_i` at the clock edge that ends the last OE cycle. It is returned with `rsp_err`=0 in a `rsp_valid` pulse one cycle later. The response arrives recovery+latency+strobe+hold+1 cycles after the accepting edge.
- R8: Data bus drive. `bus_dq_oe` is high only during write strobe and write hold cycles. While it is high, `bus_dq_o` carries the request's write data.
- R9: Reset state. After reset, `req_ready`=1 and all chip selects, OE, WE and ADV are high. `bus_dq_oe`=0 and `rsp_valid`=0. Every timing field is zero.
- R10: Configuration timing. A configuration write applies from the next accepted access. A write on the same clock edge that accepts a request does not change that request's timing.
- R11: Configuration word layout. `cfg_idx` selects chip select 0..5. The fields of `cfg_wdata` are: bits [3:0] recovery, [7:4] write hold, [11:8] read wait, [15:12] write wait, [23:16] read delta, [31:24] write delta. Writes with `cfg_idx` 6 or 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | System byte address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Address fell outside every window |
| rsp_rdata | output | 16 | Read data (zero for writes and errors) |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_idx | input | 3 | Chip select whose timing word is written |
| cfg_wdata | input | 32 | Timing word |
| bus_cs_n | output | 6 | Active-low chip selects |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_we_n | output | 1 | Active-low write enable |
| bus_adv_n | output | 1 | Active-low address valid |
| bus_addr | output | 9 | External halfword address |
| bus_dq_o | output | 16 | Data driven to the bus |
| bus_dq_oe | output | 1 | Drive enable for bus_dq_o |
| bus_dq_i | input | 16 | Data read from the bus |

## Verification
A configuration write and the acceptance of a request can fall on the same clock edge. The bench provokes this by raising `cfg_we` together with `req_valid` while the controller is idle, which changes the read wait of the chip select being accessed. The strobe width and response latency of that access must follow the old timing word, and the next read on the same chip select must follow the new one. A second coincidence is recovery and first-access latency in one access, for example a write to a new page just after a read. Both phases must appear in order, and their cycle counts are checked one by one.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   localparam int unsigned MAX_CS   = 6;
   localparam int unsigned CFG_W    = 32;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RECOV,
      ST_DELTA,
      ST_STROBE,
      ST_HOLD
   } seq_state_e;

   // packed MSB first: wr_delta sits in [31:24], recov in [3:0]
   typedef struct packed {
      logic [7:0] wr_delta;
      logic [7:0] rd_delta;
      logic [3:0] wr_wait;
      logic [3:0] rd_wait;
      logic [3:0] wr_hold;
      logic [3:0] recov;
   } cs_timing_t;

   function automatic logic [31:0] win_base(input int unsigned i);
      logic [31:0] b;
      case (i)
         0:       b = 32'h1A80_0000;
         1:       b = 32'h1B00_0000;
         2:       b = 32'h1B80_0000;
         3:       b = 32'h1D00_0000;
         4:       b = 32'h1C80_0000;
         default: b = 32'h1C00_0000;
      endcase
      return b;
   endfunction

   function automatic logic [31:0] win_size(input int unsigned i);
      return (i == 3) ? 32'h0800_0000 : 32'h0080_0000;
   endfunction

endpackage

// File: rtl/xbus_decode.sv
module xbus_decode #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned NUM_CS = 6,
   parameter int unsigned BA_W   = 9,
   parameter int unsigned IDX_W  = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  idx,
   output logic [BA_W-1:0]   ba
);

   logic [NUM_CS-1:0] hit_vec;
   logic [BA_W-1:0]   ba_vec [NUM_CS];

   for (genvar i = 0; i < NUM_CS; i++) begin : g_win
      localparam logic [ADDR_W-1:0] LO = ADDR_W'(xbus_pkg::win_base(i));
      localparam logic [ADDR_W-1:0] HI = ADDR_W'(xbus_pkg::win_base(i) + xbus_pkg::win_size(i));
      logic [ADDR_W-1:0] offs;
      assign offs       = addr - LO;
      assign hit_vec[i] = (addr >= LO) && (addr < HI);
      assign ba_vec[i]  = BA_W'(offs >> 1);
   end

   always_comb begin
      idx = '0;
      ba  = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (hit_vec[i]) begin
            idx = IDX_W'(i);
            ba  = ba_vec[i];
         end
      end
   end

   assign hit = |hit_vec;

   // R1: windows never overlap
   always_comb begin
      a_r1_single_window: assert ($onehot0(hit_vec))
         else $error("address matched more than one window");
   end

endmodule

// File: rtl/xbus_cfg_regs.sv
module xbus_cfg_regs #(
   parameter int unsigned NUM_CS = 6,
   parameter int unsigned IDX_W  = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [IDX_W-1:0]           cfg_idx,
   input  logic [xbus_pkg::CFG_W-1:0] cfg_wdata,
   output xbus_pkg::cs_timing_t       timing [NUM_CS]
);

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      xbus_pkg::cs_timing_t word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (cfg_we && (cfg_idx == IDX_W'(i))) begin
            word_q <= xbus_pkg::cs_timing_t'(cfg_wdata);
         end
      end
      assign timing[i] = word_q;
   end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
   parameter int unsigned NUM_CS   = 6,
   parameter int unsigned IDX_W    = 3,
   parameter int unsigned BA_W     = 9,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned PG_OFF_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 req_ready,
   input  logic                 dec_hit,
   input  logic [IDX_W-1:0]     dec_idx,
   input  logic [BA_W-1:0]      dec_ba,
   input  xbus_pkg::cs_timing_t timing [NUM_CS],
   output logic                 rsp_valid,
   output logic                 rsp_err,
   output logic [DATA_W-1:0]    rsp_rdata,
   output logic [NUM_CS-1:0]    bus_cs_n,
   output logic                 bus_oe_n,
   output logic                 bus_we_n,
   output logic                 bus_adv_n,
   output logic [BA_W-1:0]      bus_addr,
   output logic [DATA_W-1:0]    bus_dq_o,
   output logic                 bus_dq_oe,
   input  logic [DATA_W-1:0]    bus_dq_i
);
   import xbus_pkg::*;

   localparam int unsigned PG_W  = BA_W - PG_OFF_W;
   localparam int unsigned CNT_W = 8;

   seq_state_e         st_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [IDX_W-1:0]   cur_cs_q;
   logic               cur_wr_q;
   logic [BA_W-1:0]    cur_ba_q;
   logic [DATA_W-1:0]  wdata_q;
   logic [3:0]         t_wait_q;
   logic [3:0]         t_hold_q;
   logic [7:0]         t_delta_q;
   logic               first_q;

   // history used for recovery and page detection
   logic               prev_valid_q;
   logic               prev_read_q;
   logic [IDX_W-1:0]   prev_cs_q;
   logic               rpg_valid_q, wpg_valid_q;
   logic [IDX_W-1:0]   rpg_cs_q, wpg_cs_q;
   logic [PG_W-1:0]    rpg_q, wpg_q;

   logic               rsp_v_q, rsp_e_q;
   logic [DATA_W-1:0]  rsp_d_q;

   // acceptance-time decisions
   cs_timing_t         sel_t;
   logic [3:0]         prev_rec;
   logic               need_rec;
   logic [CNT_W-1:0]   rec_len;
   logic [PG_W-1:0]    dec_pg;
   logic               new_pg;
   logic [7:0]         acc_delta;
   logic [3:0]         acc_wait;

   always_comb begin
      sel_t     = timing[dec_idx];
      prev_rec  = timing[prev_cs_q].recov;
      need_rec  = prev_valid_q && prev_read_q && ((prev_cs_q != dec_idx) || req_write);
      rec_len   = (prev_rec == 4'd0) ? CNT_W'(1) : CNT_W'(prev_rec);
      dec_pg    = dec_ba[BA_W-1:PG_OFF_W];
      if (req_write)
         new_pg = !wpg_valid_q || (wpg_cs_q != dec_idx) || (wpg_q != dec_pg);
      else
         new_pg = !rpg_valid_q || (rpg_cs_q != dec_idx) || (rpg_q != dec_pg);
      acc_delta = new_pg ? (req_write ? sel_t.wr_delta : sel_t.rd_delta) : 8'd0;
      acc_wait  = req_write ? sel_t.wr_wait : sel_t.rd_wait;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         cnt_q        <= '0;
         cur_cs_q     <= '0;
         cur_wr_q     <= 1'b0;
         cur_ba_q     <= '0;
         wdata_q      <= '0;
         t_wait_q     <= '0;
         t_hold_q     <= '0;
         t_delta_q    <= '0;
         first_q      <= 1'b0;
         prev_valid_q <= 1'b0;
         prev_read_q  <= 1'b0;
         prev_cs_q    <= '0;
         rpg_valid_q  <= 1'b0;
         wpg_valid_q  <= 1'b0;
         rpg_cs_q     <= '0;
         wpg_cs_q     <= '0;
         rpg_q        <= '0;
         wpg_q        <= '0;
         rsp_v_q      <= 1'b0;
         rsp_e_q      <= 1'b0;
         rsp_d_q      <= '0;
      end else begin
         rsp_v_q <= 1'b0;
         first_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (!dec_hit) begin
                     rsp_v_q <= 1'b1;
                     rsp_e_q <= 1'b1;
                     rsp_d_q <= '0;
                  end else begin
                     cur_cs_q     <= dec_idx;
                     cur_wr_q     <= req_write;
                     cur_ba_q     <= dec_ba;
                     wdata_q      <= req_wdata;
                     t_wait_q     <= acc_wait;
                     t_hold_q     <= sel_t.wr_hold;
                     t_delta_q    <= acc_delta;
                     prev_valid_q <= 1'b1;
                     prev_read_q  <= !req_write;
                     prev_cs_q    <= dec_idx;
                     if (req_write) begin
                        wpg_valid_q <= 1'b1;
                        wpg_cs_q    <= dec_idx;
                        wpg_q       <= dec_pg;
                     end else begin
                        rpg_valid_q <= 1'b1;
                        rpg_cs_q    <= dec_idx;
                        rpg_q       <= dec_pg;
                     end
                     if (need_rec) begin
                        st_q  <= ST_RECOV;
                        cnt_q <= rec_len - 1'b1;
                     end else if (acc_delta != 8'd0) begin
                        st_q  <= ST_DELTA;
                        cnt_q <= CNT_W'(acc_delta) - 1'b1;
                     end else begin
                        st_q    <= ST_STROBE;
                        cnt_q   <= CNT_W'(acc_wait);
                        first_q <= 1'b1;
                     end
                  end
               end
            end
            ST_RECOV: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (t_delta_q != 8'd0) begin
                  st_q  <= ST_DELTA;
                  cnt_q <= CNT_W'(t_delta_q) - 1'b1;
               end else begin
                  st_q    <= ST_STROBE;
                  cnt_q   <= CNT_W'(t_wait_q);
                  first_q <= 1'b1;
               end
            end
            ST_DELTA: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else begin
                  st_q    <= ST_STROBE;
                  cnt_q   <= CNT_W'(t_wait_q);
                  first_q <= 1'b1;
               end
            end
            ST_STROBE: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (cur_wr_q) begin
                  st_q  <= ST_HOLD;
                  cnt_q <= CNT_W'(t_hold_q);
               end else begin
                  st_q    <= ST_IDLE;
                  rsp_v_q <= 1'b1;
                  rsp_e_q <= 1'b0;
                  rsp_d_q <= bus_dq_i;
               end
            end
            ST_HOLD: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else begin
                  st_q    <= ST_IDLE;
                  rsp_v_q <= 1'b1;
                  rsp_e_q <= 1'b0;
                  rsp_d_q <= '0;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   logic cs_active;
   assign cs_active = (st_q == ST_DELTA) || (st_q == ST_STROBE) || (st_q == ST_HOLD);

   for (genvar i = 0; i < NUM_CS; i++) begin : g_csn
      assign bus_cs_n[i] = !(cs_active && (cur_cs_q == IDX_W'(i)));
   end

   assign req_ready = (st_q == ST_IDLE);
   assign bus_oe_n  = !((st_q == ST_STROBE) && !cur_wr_q);
   assign bus_we_n  = !((st_q == ST_STROBE) && cur_wr_q);
   assign bus_adv_n = !((st_q == ST_STROBE) && first_q);
   assign bus_dq_oe = cur_wr_q && ((st_q == ST_STROBE) || (st_q == ST_HOLD));
   assign bus_addr  = cur_ba_q;
   assign bus_dq_o  = wdata_q;
   assign rsp_valid = rsp_v_q;
   assign rsp_err   = rsp_e_q;
   assign rsp_rdata = rsp_d_q;

   // R1: at most one chip select active
   a_r1_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~bus_cs_n));

   // R2: error responses carry zero data
   a_r2_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

   // R3: address valid only marks the opening edge of a strobe
   a_r3_adv_first: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_adv_n |-> $fell(bus_oe_n && bus_we_n));

   // R4: a write strobe is always followed by a hold cycle
   a_r4_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_we_n) |-> (bus_dq_oe && !(&bus_cs_n)));

   // R6: no strobe or drive while every chip select is high
   a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (&bus_cs_n) |-> (bus_oe_n && bus_we_n && bus_adv_n && !bus_dq_oe));

   // R7: a response only appears while a new request can be taken
   a_r7_rsp_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready);

   // R8: never drive the data bus while the device may drive it
   a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dq_oe |-> (bus_oe_n && !(&bus_cs_n)));

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned BA_W     = 9,
   parameter int unsigned NUM_CS   = 6,
   parameter int unsigned PG_OFF_W = 4,
   localparam int unsigned IDX_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   output logic                       req_ready,
   input  logic                       req_write,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [DATA_W-1:0]          req_wdata,
   output logic                       rsp_valid,
   output logic                       rsp_err,
   output logic [DATA_W-1:0]          rsp_rdata,
   input  logic                       cfg_we,
   input  logic [IDX_W-1:0]           cfg_idx,
   input  logic [xbus_pkg::CFG_W-1:0] cfg_wdata,
   output logic [NUM_CS-1:0]          bus_cs_n,
   output logic                       bus_oe_n,
   output logic                       bus_we_n,
   output logic                       bus_adv_n,
   output logic [BA_W-1:0]            bus_addr,
   output logic [DATA_W-1:0]          bus_dq_o,
   output logic                       bus_dq_oe,
   input  logic [DATA_W-1:0]          bus_dq_i
);

   initial begin
      a_cfg_num_cs: assert (NUM_CS >= 1 && NUM_CS <= xbus_pkg::MAX_CS)
         else $error("NUM_CS out of range");
      a_cfg_addr_w: assert (ADDR_W == 32)
         else $error("window map needs a 32-bit address");
      a_cfg_ba_w: assert (BA_W > PG_OFF_W && BA_W < ADDR_W)
         else $error("bus address width inconsistent");
      a_cfg_data_w: assert (DATA_W >= 8)
         else $error("data width too small");
   end

   logic                 dec_hit;
   logic [IDX_W-1:0]     dec_idx;
   logic [BA_W-1:0]      dec_ba;
   xbus_pkg::cs_timing_t timing [NUM_CS];

   xbus_decode #(
      .ADDR_W (ADDR_W),
      .NUM_CS (NUM_CS),
      .BA_W   (BA_W),
      .IDX_W  (IDX_W)
   ) u_decode (
      .addr (req_addr),
      .hit  (dec_hit),
      .idx  (dec_idx),
      .ba   (dec_ba)
   );

   xbus_cfg_regs #(
      .NUM_CS (NUM_CS),
      .IDX_W  (IDX_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_wdata (cfg_wdata),
      .timing    (timing)
   );

   xbus_seq #(
      .NUM_CS   (NUM_CS),
      .IDX_W    (IDX_W),
      .BA_W     (BA_W),
      .DATA_W   (DATA_W),
      .PG_OFF_W (PG_OFF_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_wdata (req_wdata),
      .req_ready (req_ready),
      .dec_hit   (dec_hit),
      .dec_idx   (dec_idx),
      .dec_ba    (dec_ba),
      .timing    (timing),
      .rsp_valid (rsp_valid),
      .rsp_err   (rsp_err),
      .rsp_rdata (rsp_rdata),
      .bus_cs_n  (bus_cs_n),
      .bus_oe_n  (bus_oe_n),
      .bus_we_n  (bus_we_n),
      .bus_adv_n (bus_adv_n),
      .bus_addr  (bus_addr),
      .bus_dq_o  (bus_dq_o),
      .bus_dq_oe (bus_dq_oe),
      .bus_dq_i  (bus_dq_i)
   );

endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [15:0] rsp_rdata;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic [5:0]  bus_cs_n;
   logic        bus_oe_n, bus_we_n, bus_adv_n, bus_dq_oe;
   logic [8:0]  bus_addr;
   logic [15:0] bus_dq_o, bus_dq_i;

   always #10 clk = ~clk;

   xbus_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
      .bus_adv_n(bus_adv_n), .bus_addr(bus_addr), .bus_dq_o(bus_dq_o),
      .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i)
   );

   int total = 0;
   int bad = 0;

   task automatic check(string tag, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   typedef struct packed {
      bit        err;
      bit        wr;
      bit [15:0] rdata;
      bit [15:0] wd;
      bit [8:0]  ba;
      int        cs;
      int        lat;
      int        rec;
      int        dly;
      int        stb;
      int        hld;
   } exp_t;

   exp_t q[$];

   // ---------------- device model ----------------
   function automatic logic [15:0] pat(int cs, logic [8:0] ba);
      return {cs[2:0], ba, 4'h3};
   endfunction

   function automatic int low_cs(logic [5:0] csn);
      int r = 0;
      for (int i = 0; i < 6; i++) if (!csn[i]) r = i;
      return r;
   endfunction

   logic [4:0] oe_cnt = '0;
   always @(posedge clk) oe_cnt <= !bus_oe_n ? oe_cnt + 5'd1 : 5'd0;
   assign bus_dq_i = !bus_oe_n ? pat(low_cs(bus_cs_n), bus_addr) + 16'(oe_cnt) : 16'h0;

   // ---------------- reference model ----------------
   logic [31:0] shadow [6];
   bit  p_valid = 0, p_read = 0;
   int  p_cs = 0;
   bit  rv = 0, wv = 0;
   int  rcs = 0, wcs = 0;
   logic [4:0] rpg = '0, wpg = '0;

   function automatic logic [31:0] tb_base(int i);
      case (i)
         0: return 32'h1A80_0000;
         1: return 32'h1B00_0000;
         2: return 32'h1B80_0000;
         3: return 32'h1D00_0000;
         4: return 32'h1C80_0000;
         default: return 32'h1C00_0000;
      endcase
   endfunction

   task automatic predict(bit wr, logic [31:0] a, logic [15:0] wd, output exp_t e);
      int cs = -1;
      logic [31:0] off;
      logic [31:0] w;
      int rc, wt;
      bit np;
      e = '0;
      e.wr = wr;
      e.wd = wd;
      for (int i = 0; i < 6; i++) begin
         logic [31:0] sz = (i == 3) ? 32'h0800_0000 : 32'h0080_0000;
         if (a >= tb_base(i) && a < tb_base(i) + sz) cs = i;
      end
      if (cs < 0) begin
         e.err = 1;
         e.lat = 1;
         return;
      end
      off  = a - tb_base(cs);
      e.ba = off[9:1];
      e.cs = cs;
      w    = shadow[cs];
      if (p_valid && p_read && (p_cs != cs || wr)) begin
         rc = int'(shadow[p_cs][3:0]);
         e.rec = (rc == 0) ? 1 : rc;
      end
      np = wr ? (!wv || wcs != cs || wpg != e.ba[8:4]) : (!rv || rcs != cs || rpg != e.ba[8:4]);
      if (np) e.dly = wr ? int'(w[31:24]) : int'(w[23:16]);
      wt    = wr ? int'(w[15:12]) : int'(w[11:8]);
      e.stb = wt + 1;
      e.hld = wr ? int'(w[7:4]) + 1 : 0;
      e.rdata = wr ? 16'h0 : pat(cs, e.ba) + 16'(wt);
      e.lat = e.rec + e.dly + e.stb + e.hld + 1;
      p_valid = 1;
      p_read  = !wr;
      p_cs    = cs;
      if (wr) begin wv = 1; wcs = cs; wpg = e.ba[8:4]; end
      else    begin rv = 1; rcs = cs; rpg = e.ba[8:4]; end
   endtask

   // ---------------- monitor / scoreboard ----------------
   int   m_lat = 0, m_rec = 0, m_dly = 0, m_stb = 0, m_hld = 0, m_adv = 0;
   int   m_cs = 0, m_baddq = 0, m_cont = 0;
   bit   seen_cs = 0, seen_stb = 0;
   logic [8:0] m_ba = '0;
   exp_t ce;

   always @(negedge clk) begin
      if (rst_n) begin
         m_lat++;
         if (rsp_valid) begin
            if (q.size() == 0) begin
               check("R7 unexpected response", 1, 0);
            end else begin
               ce = q.pop_front();
               check("R7 response latency", m_lat, ce.lat);
               if (ce.err) begin
                  check("R2 error flag", rsp_err, 1);
                  check("R2 error data", rsp_rdata, 0);
                  check("R2 no strobe", m_stb, 0);
                  check("R2 no chip select", seen_cs, 0);
               end else begin
                  check("R7 error flag clear", rsp_err, 0);
                  check(ce.wr ? "R4 write response data" : "R7 read data", rsp_rdata, ce.rdata);
                  check("R1 chip select", m_cs, ce.cs);
                  check("R1 bus address", m_ba, ce.ba);
                  check("R3 strobe width", m_stb, ce.stb);
                  check("R3 adv cycles", m_adv, 1);
                  check("R4 hold cycles", m_hld, ce.hld);
                  check("R5 delta cycles", m_dly, ce.dly);
                  check("R6 recovery cycles", m_rec, ce.rec);
                  check("R8 data drive", m_baddq, 0);
                  check("R8 contention", m_cont, 0);
               end
            end
         end else begin
            if (&bus_cs_n) begin
               if (!seen_cs) m_rec++;
            end else begin
               seen_cs = 1;
               m_cs = low_cs(bus_cs_n);
            end
            if (!bus_oe_n || !bus_we_n) begin
               m_stb++;
               seen_stb = 1;
               m_ba = bus_addr;
            end else if (!(&bus_cs_n) && !seen_stb) begin
               m_dly++;
            end
            if (bus_we_n && bus_dq_oe) m_hld++;
            if (!bus_adv_n) m_adv++;
            if (bus_dq_oe && (q.size() == 0 || !q[0].wr || bus_dq_o != q[0].wd)) m_baddq++;
            if (bus_dq_oe && !bus_oe_n) m_cont++;
         end
         if (req_valid && req_ready) begin
            m_lat = 0; m_rec = 0; m_dly = 0; m_stb = 0; m_hld = 0; m_adv = 0;
            m_baddq = 0; m_cont = 0; seen_cs = 0; seen_stb = 0;
         end
      end
   end

   // ---------------- driver ----------------
   task automatic cfg_write(logic [2:0] idx, logic [31:0] d);
      @(posedge clk); #2;
      cfg_we = 1; cfg_idx = idx; cfg_wdata = d;
      @(posedge clk); #2;
      cfg_we = 0;
      if (idx < 6) shadow[idx] = d;
   endtask

   task automatic access(bit wr, logic [31:0] a, logic [15:0] wd,
                         bit with_cfg = 0, logic [2:0] ci = 0, logic [31:0] cd = 0);
      exp_t e;
      predict(wr, a, wd, e);
      q.push_back(e);
      @(posedge clk); #2;
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
      if (with_cfg) begin cfg_we = 1; cfg_idx = ci; cfg_wdata = cd; end
      @(posedge clk); #2;
      req_valid = 0; cfg_we = 0;
      if (with_cfg && ci < 6) shadow[ci] = cd;
      while (q.size() != 0) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 6; i++) shadow[i] = '0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(negedge clk);
      // R9 reset state
      check("R9 ready", req_ready, 1);
      check("R9 chip selects", bus_cs_n, 6'h3F);
      check("R9 strobes", {bus_oe_n, bus_we_n, bus_adv_n}, 3'b111);
      check("R9 drive", bus_dq_oe, 0);
      check("R9 response", rsp_valid, 0);

      // R1 every window at minimum timing, including window edges
      access(0, 32'h1A80_0010, 0);
      access(0, 32'h1B00_0222, 0);
      access(1, 32'h1B80_0100, 16'hA1B2);
      access(0, 32'h1D00_0040, 0);
      access(1, 32'h1C80_0006, 16'h0F0F);
      access(0, 32'h1C00_03FE, 0);
      access(0, 32'h1AFF_FFFE, 0);
      access(0, 32'h24FF_FFFE, 0);
      access(1, 32'h1C7F_FFFE, 16'h1234);

      // R2 unmapped addresses on both sides of the map
      access(0, 32'h1A7F_FFFE, 0);
      access(1, 32'h2500_0000, 16'hFFFF);
      access(0, 32'h0000_0000, 0);

      // R11 timing word for chip select 2, then R5 R6 R3 R4 patterns
      cfg_write(3'd2, 32'h0907_5423);
      access(0, 32'h1B80_0020, 0);          // new read page: delta, recovery from cs5 write? none
      access(0, 32'h1B80_0024, 0);          // same page: no delta, no recovery
      access(0, 32'h1B80_0060, 0);          // page change: delta again
      access(1, 32'h1B80_0062, 16'hBEEF);   // read->write same cs: recovery + write delta
      access(1, 32'h1B80_0064, 16'hC0DE);   // write same page: nothing extra
      access(0, 32'h1B80_0066, 0);          // write->read: no recovery
      access(0, 32'h1D00_0040, 0);          // cs change after read: cs2 recovery 3
      access(0, 32'h1C80_0000, 0);          // cs3 recovery field 0 gives 1 cycle
      access(0, 32'h1C80_0002, 0);          // idle gap then same cs read

      // R10 configuration write coinciding with acceptance
      access(0, 32'h1B80_0068, 0, 1, 3'd2, 32'h0907_5123);
      access(0, 32'h1B80_006A, 0);

      // R11 out-of-range index ignored
      cfg_write(3'd6, 32'hFFFF_FFFF);
      cfg_write(3'd7, 32'hFFFF_FFFF);
      for (int i = 0; i < 6; i++) access(0, tb_base(i) + 32'h80, 0);
      access(1, 32'h1A80_0200, 16'h5555);

      repeat (3) @(negedge clk);
      check("R7 scoreboard drained", q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule